// File: doc/BRIEF.md
# Time-Slot-List Audio Playback Serializer

This block turns a stream of 32-bit playback words into a serial audio signal. An external read engine writes the words into an output FIFO. A list of one-byte entries, held outside the block, sets what each byte slot of a super frame carries. An entry can ask for a fresh FIFO word in a 32-bit holding buffer before its slot. It names one of eight bytes to send: the four bytes of the holding buffer or the four bytes of a feedback word. It also names which serial-data pin carries the byte.

Bit timing comes from a half-period strobe that the clock generator supplies. Each strobe flips the internal bit-clock phase. Data moves on every second strobe. A control input inverts the outgoing bit clock, so a receiver can sample on either edge. A frame marker is high while slot 0 is on the line. If a reload is asked for while the FIFO is empty, the old holding word is reused and a sticky flag is raised.

Top module: `tsl_playout`

## Requirements
- R1: After reset, every serial-data pin and every pin enable is 0, the frame marker and the underrun flag are 0, the FIFO is empty and not full, and the bit-clock output equals the inversion input.
- R2: A list entry is 8 bits: bits [2:0] select the source byte, bit 3 requests a reload, bits [5:4] select the output pin, bit 6 ends the frame, and bit 7 is ignored. Source values 0 to 3 pick holding-buffer byte 0 to 3 and values 4 to 7 pick feedback byte 0 to 3. Byte k means bits 8k+7 down to 8k.
- R3: When the next entry has its reload bit set and the FIFO holds data, the oldest FIFO word is moved into the holding buffer, and that slot's byte is chosen from the new word. When the reload bit is clear, the FIFO is not read.
- R4: Each slot carries 8 bits, MSB first. The line shows bit 7 after the first data strobe of the slot, and the next lower bit after each later data strobe. Serial data changes only on a cycle that follows a strobe.
- R5: Only the pin selected by the current entry is enabled and carries the data bit. All other pins are driven 0. At most one enable is high.
- R6: Slots run in order from entry 0. After an entry with the end-of-frame bit, or after the last entry, the next slot is entry 0. The frame marker is high exactly while entry 0 is being sent.
- R7: Every half-period strobe flips the bit-clock phase. Data strobes are the ones on which the phase rises from 0 to 1. The bit-clock output is the phase XOR the inversion input.
- R8: A reload request while the FIFO is empty keeps the previous holding word and sets the underrun flag. The flag stays set until reset.
- R9: The FIFO returns words in the order they were written. It asserts full at its depth, and a write while full is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | FIFO write strobe from the read engine |
| wr_data | input | 32 | Word to write into the FIFO |
| fifo_full | output | 1 | FIFO is at its depth |
| half_en | input | 1 | Half bit-period strobe |
| bclk_inv | input | 1 | Inverts the outgoing bit clock |
| slot_list | input | NUM_SLOTS*8 | Packed list entries, entry n at bits 8n+7 down to 8n |
| fb_word | input | 32 | Feedback word, the second source of bytes |
| bclk_out | output | 1 | Bit clock |
| ws_out | output | 1 | Frame marker, high during entry 0 |
| sd_out | output | NUM_PINS | Serial-data pins |
| sd_oe | output | NUM_PINS | Pin enables, at most one high |
| underrun | output | 1 | Sticky flag for a reload from an empty FIFO |

## Verification
The bench builds the block with a four-entry list and a four-word FIFO. With these sizes the wrap after the last entry, the early wrap on an end-of-frame entry, a full FIFO that drops a write, and a reload from an empty FIFO all come up within a few frames. The remaining cases come from random lists, feedback words and write patterns. The bench also toggles the clock inversion and applies a second reset to clear the sticky flag.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int BYTE_W  = 8;
  localparam int WORD_W  = 32;
  localparam int ENTRY_W = 8;

  typedef struct packed {
    logic       spare;
    logic       eof;
    logic [1:0] pin;
    logic       reload;
    logic [2:0] src;
  } tsl_entry_t;

  // Source 0..3 selects a byte of the holding word, 4..7 a byte of the feedback word
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [2:0] src,
                                                   input logic [WORD_W-1:0] hold,
                                                   input logic [WORD_W-1:0] fb);
    logic [WORD_W-1:0] w;
    w = src[2] ? fb : hold;
    return w[src[1:0]*BYTE_W +: BYTE_W];
  endfunction
endpackage

// File: rtl/tsl_fifo.sv
module tsl_fifo #(
  parameter int DEPTH = 24,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push, pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign push    = wr_en && !full;
  assign pop     = rd_en && !empty;
  assign rd_data = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/tsl_slot_seq.sv
module tsl_slot_seq
  import tsl_pkg::*;
#(
  parameter int NUM_SLOTS = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       half_en,
  input  logic [NUM_SLOTS*ENTRY_W-1:0] slot_list,
  input  logic [WORD_W-1:0]          fb_word,
  input  logic [WORD_W-1:0]          fifo_head,
  input  logic                       fifo_empty,
  output logic                       fifo_pop,
  output logic                       load_evt,
  output logic                       shift_evt,
  output logic                       phase,
  output logic                       active,
  output logic                       data_bit,
  output logic [1:0]                 pin_sel,
  output logic                       frame_mark,
  output logic                       underrun
);
  localparam int IDX_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  logic [IDX_W-1:0]  idx, nxt_idx;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [WORD_W-1:0] hold, hold_nx;
  tsl_entry_t        cur_e, nxt_e;
  logic              boundary, starve;

  assign cur_e    = tsl_entry_t'(slot_list[idx*ENTRY_W +: ENTRY_W]);
  assign nxt_idx  = (!active || cur_e.eof || idx == IDX_W'(NUM_SLOTS - 1)) ? '0 : idx + 1'b1;
  assign nxt_e    = tsl_entry_t'(slot_list[nxt_idx*ENTRY_W +: ENTRY_W]);

  assign boundary  = half_en && !phase;
  assign load_evt  = boundary && (!active || bit_cnt == 3'd7);
  assign shift_evt = boundary && !load_evt;
  assign fifo_pop  = load_evt && nxt_e.reload && !fifo_empty;
  assign starve    = load_evt && nxt_e.reload && fifo_empty;
  assign hold_nx   = fifo_pop ? fifo_head : hold;

  assign data_bit   = shreg[BYTE_W-1];
  assign frame_mark = active && (idx == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= 1'b0;
      active   <= 1'b0;
      idx      <= '0;
      bit_cnt  <= '0;
      shreg    <= '0;
      hold     <= '0;
      pin_sel  <= '0;
      underrun <= 1'b0;
    end else begin
      if (half_en) phase <= !phase;
      if (starve)  underrun <= 1'b1;
      if (load_evt) begin
        active  <= 1'b1;
        idx     <= nxt_idx;
        bit_cnt <= '0;
        hold    <= hold_nx;
        pin_sel <= nxt_e.pin;
        shreg   <= pick_byte(nxt_e.src, hold_nx, fb_word);
      end else if (shift_evt) begin
        bit_cnt <= bit_cnt + 1'b1;
        shreg   <= {shreg[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/tsl_playout.sv
module tsl_playout
  import tsl_pkg::*;
#(
  parameter int NUM_SLOTS  = 32,
  parameter int FIFO_DEPTH = 24,
  parameter int NUM_PINS   = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [WORD_W-1:0]            wr_data,
  output logic                         fifo_full,
  input  logic                         half_en,
  input  logic                         bclk_inv,
  input  logic [NUM_SLOTS*ENTRY_W-1:0] slot_list,
  input  logic [WORD_W-1:0]            fb_word,
  output logic                         bclk_out,
  output logic                         ws_out,
  output logic [NUM_PINS-1:0]          sd_out,
  output logic [NUM_PINS-1:0]          sd_oe,
  output logic                         underrun
);
  logic [WORD_W-1:0] fifo_head;
  logic              fifo_empty, pop_evt, load_evt, shift_evt;
  logic              phase, active, data_bit;
  logic [1:0]        pin_sel;

  tsl_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(pop_evt), .rd_data(fifo_head), .empty(fifo_empty), .full(fifo_full)
  );

  tsl_slot_seq #(.NUM_SLOTS(NUM_SLOTS)) u_seq (
    .clk(clk), .rst_n(rst_n), .half_en(half_en), .slot_list(slot_list),
    .fb_word(fb_word), .fifo_head(fifo_head), .fifo_empty(fifo_empty),
    .fifo_pop(pop_evt), .load_evt(load_evt), .shift_evt(shift_evt),
    .phase(phase), .active(active), .data_bit(data_bit), .pin_sel(pin_sel),
    .frame_mark(ws_out), .underrun(underrun)
  );

  assign bclk_out = phase ^ bclk_inv;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign sd_oe[i]  = active && (pin_sel == 2'(i));
    assign sd_out[i] = sd_oe[i] && data_bit;
  end
endmodule

// File: rtl/tsl_playout_chk.sv
module tsl_playout_chk #(
  parameter int NUM_PINS = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                half_en,
  input logic                bclk_inv,
  input logic                bclk_out,
  input logic                wr_en,
  input logic                fifo_full,
  input logic                fifo_empty,
  input logic                pop_evt,
  input logic                load_evt,
  input logic [NUM_PINS-1:0] sd_out,
  input logic [NUM_PINS-1:0] sd_oe,
  input logic                underrun
);
  AST_OE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(sd_oe)); // R5
  AST_SD_INSIDE_OE: assert property (@(posedge clk) disable iff (!rst_n) (sd_out & ~sd_oe) == '0); // R5
  AST_SD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) !half_en |=> $stable(sd_out)); // R4
  AST_BCLK_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    half_en |=> ((bclk_out ^ bclk_inv) != $past(bclk_out ^ bclk_inv))); // R7
  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) underrun |=> underrun); // R8
  AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) pop_evt |-> (!fifo_empty && load_evt)); // R3
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full && !pop_evt) |=> fifo_full); // R9
endmodule

bind tsl_playout tsl_playout_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_en(half_en), .bclk_inv(bclk_inv),
  .bclk_out(bclk_out), .wr_en(wr_en), .fifo_full(fifo_full),
  .fifo_empty(fifo_empty), .pop_evt(pop_evt), .load_evt(load_evt),
  .sd_out(sd_out), .sd_oe(sd_oe), .underrun(underrun)
);

// File: tb/tsl_playout_bench.sv
module tsl_playout_bench;
  localparam int NS = 4;
  localparam int FD = 4;
  localparam int NP = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0;
  logic [31:0]     wr_data = '0;
  logic            fifo_full;
  logic            half_en = 1'b0;
  logic            bclk_inv = 1'b0;
  logic [NS*8-1:0] lst = '0;
  logic [31:0]     fb = '0;
  logic            bclk_out, ws_out, underrun;
  logic [NP-1:0]   sd_out, sd_oe;

  int n_chk = 0, n_fail = 0;
  logic [31:0] q [FD];
  int q_rd = 0, q_cnt = 0;
  logic [31:0] m_hold = '0;
  logic m_act = 0, m_under = 0;
  int m_idx = 0;

  always #5 clk = ~clk;

  tsl_playout #(.NUM_SLOTS(NS), .FIFO_DEPTH(FD), .NUM_PINS(NP)) u_tsl_playout (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
    .half_en(half_en), .bclk_inv(bclk_inv), .slot_list(lst), .fb_word(fb),
    .bclk_out(bclk_out), .ws_out(ws_out), .sd_out(sd_out), .sd_oe(sd_oe), .underrun(underrun)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] src_byte(input logic [2:0] s, input logic [31:0] h, input logic [31:0] f);
    case (s)
      3'd0: return h[7:0];
      3'd1: return h[15:8];
      3'd2: return h[23:16];
      3'd3: return h[31:24];
      3'd4: return f[7:0];
      3'd5: return f[15:8];
      3'd6: return f[23:16];
      default: return f[31:24];
    endcase
  endfunction

  function automatic logic [7:0] entry(input int n);
    return lst[n*8 +: 8];
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    q_rd = 0; q_cnt = 0; m_hold = '0; m_act = 0; m_under = 0; m_idx = 0;
    chk(sd_out == '0 && sd_oe == '0, "R1 pins", {sd_oe, sd_out}, 0);
    chk(ws_out == 0 && underrun == 0 && fifo_full == 0, "R1 flags", {ws_out, underrun, fifo_full}, 0);
    chk(bclk_out == bclk_inv, "R1 bclk", bclk_out, bclk_inv);
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
    if (q_cnt < FD) begin
      q[(q_rd + q_cnt) % FD] = w;
      q_cnt++;
    end
    chk(fifo_full == (q_cnt == FD), "R9 full flag", fifo_full, q_cnt == FD);
  endtask

  task automatic half();
    @(negedge clk);
    half_en = 1'b1;
    @(negedge clk);
    half_en = 1'b0;
  endtask

  task automatic run_slot();
    logic [7:0] e, b;
    int ni;
    ni = (!m_act || entry(m_idx)[6] || m_idx == NS - 1) ? 0 : m_idx + 1;
    e = entry(ni);
    if (e[3]) begin
      if (q_cnt > 0) begin
        m_hold = q[q_rd]; q_rd = (q_rd + 1) % FD; q_cnt--;
      end else m_under = 1;
    end
    m_act = 1; m_idx = ni;
    b = src_byte(e[2:0], m_hold, fb);
    for (int k = 0; k < 8; k++) begin
      logic [NP-1:0] pin_v;
      pin_v = NP'(1) << e[5:4];
      half();
      chk(sd_out == (b[7-k] ? pin_v : '0), "R4 R2 R3 serial bit", sd_out, b[7-k] ? pin_v : '0);
      chk(sd_oe == pin_v, "R5 pin enable", sd_oe, pin_v);
      chk(ws_out == (ni == 0), "R6 frame marker", ws_out, ni == 0);
      chk(bclk_out == !bclk_inv, "R7 bclk high phase", bclk_out, !bclk_inv);
      half();
      chk(sd_out == (b[7-k] ? pin_v : '0), "R4 hold between strobes", sd_out, b[7-k] ? pin_v : '0);
      chk(bclk_out == bclk_inv, "R7 bclk low phase", bclk_out, bclk_inv);
    end
    chk(underrun == m_under, "R8 underrun", underrun, m_under);
    chk(fifo_full == (q_cnt == FD), "R3 fifo level", fifo_full, q_cnt == FD);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd7213));
    do_reset();
    // Directed: reload + holding byte 0 on pin 0, feedback byte 1 on pin 1,
    // reload + holding byte 3 on pin 2 with end of frame (R2, R3, R5, R6)
    lst = {8'h00, 8'h6B, 8'h15, 8'h08};
    fb = 32'hA55A_C33C;
    push(32'h1234_5678);
    push(32'h9ABC_DEF0);
    repeat (3) run_slot();
    run_slot(); // wraps early to entry 0, reload on an empty FIFO (R8)
    chk(underrun == 1, "R8 set on empty reload", underrun, 1);
    bclk_inv = 1'b1; // R7
    run_slot();
    run_slot();
    // FIFO fill past depth, the extra write is dropped (R9)
    for (int i = 0; i < FD + 1; i++) push(32'hC000_0000 + i);
    chk(fifo_full == 1, "R9 full at depth", fifo_full, 1);
    lst = {8'h3B, 8'h2A, 8'h19, 8'h08}; // all reload, no eof: wraps after last entry (R6)
    repeat (6) run_slot();
    do_reset(); // R1, clears R8 flag
    bclk_inv = 1'b0;
    for (int f = 0; f < 40; f++) begin
      lst = $urandom();
      fb = $urandom();
      if (f % 7 == 3) bclk_inv = ~bclk_inv;
      while (q_cnt < FD && ($urandom() % 3 != 0)) push($urandom());
      repeat (NS) run_slot();
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule